// File: doc/BRIEF.md
# Stereo Attenuation Control Register Bank

This block is the register front end that sets the output level of a two-channel audio converter. It takes single-cycle register writes, each made of a 3-bit address and a 9-bit data word. For each channel it keeps two 8-bit codes. The staged code holds whatever was last written. The active code is the one the downstream volume logic uses. A staged code becomes active only when a write carries the load flag. That single write copies both staged codes at once, including the value written in that same cycle, so the two channels can change level on the same clock edge.

For each channel the block drives the effective code, a mute flag and the attenuation depth in half-decibel steps. The level of code X is half a decibel times (X minus 255); code zero means silence. A shared-level mode bit makes the right channel follow the left active code. Three further registers hold format, filter and output options. The block decodes their fields onto dedicated output pins.

Top module: `stereo_atten_regs`

## Requirements
- R1: After reset, all staged and active codes are 0xFF (0 dB, depth 0), and every mode output is 0.
- R2: A write to address 0 (left) or address 1 (right) with data bit 8 at 0 stores data[7:0] as that channel's staged code and leaves both active codes unchanged.
- R3: A write to address 0 or 1 with data bit 8 at 1 copies both staged codes into both active codes on that same clock edge. The data[7:0] of that write is stored first and is included in the copy.
- R4: Each channel's depth output equals 255 minus its effective code, counted in 0.5 dB steps (0xFE gives 1, 0x01 gives 254).
- R5: Each channel's mute flag is 1 exactly when its effective code is 0x00.
- R6: When the shared-level bit (address 3, bit 2) is 1, the right channel's code, mute and depth follow the left active code. When it is 0, each channel uses its own active code.
- R7: A write to address 2 sets: soft mute = bit 0, de-emphasis = bit 1, converter run = bit 2, word length select = bits [4:3].
- R8: A write to address 3 sets: serial format select = bit 0, word-clock polarity = bit 1, shared level = bit 2, slow roll-off = bit 3, phase invert = bit 4, clock-out rate select = bit 5, sample-rate select = bits [7:6], zero-detect enable = bit 8.
- R9: A write to address 4 sets: differential mode = bits [5:4], clock-loss detector off = bit 6.
- R10: Writes to addresses 5 to 7, and any cycle with wr_en low, change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 9 | Register write data |
| left_code | output | 8 | Effective left attenuation code |
| right_code | output | 8 | Effective right attenuation code |
| left_mute | output | 1 | Left code is zero |
| right_mute | output | 1 | Right code is zero |
| left_depth | output | 8 | Left attenuation in 0.5 dB steps |
| right_depth | output | 8 | Right attenuation in 0.5 dB steps |
| soft_mute | output | 1 | Soft mute request |
| deemph_en | output | 1 | De-emphasis enable |
| dac_run | output | 1 | Converter operation enable |
| word_len | output | 2 | Input word length select |
| fmt_i2s | output | 1 | Serial data format select |
| lr_polarity | output | 1 | Word-clock polarity |
| shared_level | output | 1 | Right channel uses left level |
| slow_rolloff | output | 1 | Slow roll-off filter select |
| phase_invert | output | 1 | Output phase reverse |
| clkout_sel | output | 1 | Clock-out rate select |
| rate_sel | output | 2 | Sample-rate select |
| zero_detect_en | output | 1 | Zero-detect enable |
| diff_mode | output | 2 | Differential output mode |
| clkloss_off | output | 1 | Clock-loss detector disable |

## Verification
The assertions assume that wr_addr and wr_data carry known values whenever wr_en is high. They also assume that one write is one cycle, so each edge sees at most one register update. The bench keeps to this by driving every input on the falling edge, from a fixed-seed $urandom stream over all eight addresses. It pulls wr_en low between writes and biases codes toward 0x00, 0x01, 0xFE and 0xFF. Directed sequences add staged-then-loaded pairs, shared-level toggling and ignored writes before the random run.

// File: rtl/atten_regs_pkg.sv
package atten_regs_pkg;
    localparam int CODE_W   = 8;
    localparam int DATA_W   = CODE_W + 1;
    localparam int ADDR_W   = 3;
    localparam int LOAD_BIT = CODE_W;
    localparam int NCHAN    = 2;

    localparam logic [ADDR_W-1:0] ADR_LEFT  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_RIGHT = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CTL   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_FMT   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_OUT   = 3'd4;

    localparam logic [CODE_W-1:0] CODE_UNITY = '1;

    typedef struct packed {
        logic [CODE_W-1:0] stg_l;
        logic [CODE_W-1:0] stg_r;
        logic [CODE_W-1:0] act_l;
        logic [CODE_W-1:0] act_r;
    } atten_state_t;

    typedef struct packed {
        logic [1:0] word_len;
        logic       dac_run;
        logic       deemph;
        logic       soft_mute;
    } ctl_reg_t;

    typedef struct packed {
        logic       zero_det;
        logic [1:0] rate;
        logic       clkout;
        logic       phase_inv;
        logic       slow_ro;
        logic       shared;
        logic       lr_pol;
        logic       fmt;
    } fmt_reg_t;

    typedef struct packed {
        logic       clkloss_off;
        logic [1:0] diff;
    } out_reg_t;

    typedef struct packed {
        ctl_reg_t ctl;
        fmt_reg_t fmt;
        out_reg_t outm;
    } mode_state_t;
endpackage

// File: rtl/atten_stage.sv
module atten_stage
    import atten_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CODE_W-1:0] act_l,
    output logic [CODE_W-1:0] act_r
);
    atten_state_t st_d, st_q;
    logic         load_d;

    always_comb begin
        st_d   = st_q;
        load_d = 1'b0;
        if (wr_en) begin
            if (wr_addr == ADR_LEFT) begin
                st_d.stg_l = wr_data[CODE_W-1:0];
                load_d     = wr_data[LOAD_BIT];
            end else if (wr_addr == ADR_RIGHT) begin
                st_d.stg_r = wr_data[CODE_W-1:0];
                load_d     = wr_data[LOAD_BIT];
            end
        end
        if (load_d) begin
            st_d.act_l = st_d.stg_l;
            st_d.act_r = st_d.stg_r;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stg_l: CODE_UNITY, stg_r: CODE_UNITY,
                      act_l: CODE_UNITY, act_r: CODE_UNITY};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_l = st_q.act_l;
    assign act_r = st_q.act_r;

    logic chan_wr, load_wr;
    assign chan_wr = wr_en && (wr_addr == ADR_LEFT || wr_addr == ADR_RIGHT);
    assign load_wr = chan_wr && wr_data[LOAD_BIT];

    // R2
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_wr |=> ($stable(st_q.act_l) && $stable(st_q.act_r)));

    // R3
    load_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && wr_addr == ADR_LEFT) |=>
            (st_q.act_l == $past(wr_data[CODE_W-1:0]) && st_q.act_r == $past(st_q.stg_r)));

    // R3
    load_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && wr_addr == ADR_RIGHT) |=>
            (st_q.act_r == $past(wr_data[CODE_W-1:0]) && st_q.act_l == $past(st_q.stg_l)));
endmodule

// File: rtl/mode_bank.sv
module mode_bank
    import atten_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mode_state_t       mode
);
    mode_state_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_en) begin
            case (wr_addr)
                ADR_CTL: begin
                    m_d.ctl.soft_mute = wr_data[0];
                    m_d.ctl.deemph    = wr_data[1];
                    m_d.ctl.dac_run   = wr_data[2];
                    m_d.ctl.word_len  = wr_data[4:3];
                end
                ADR_FMT: begin
                    m_d.fmt.fmt       = wr_data[0];
                    m_d.fmt.lr_pol    = wr_data[1];
                    m_d.fmt.shared    = wr_data[2];
                    m_d.fmt.slow_ro   = wr_data[3];
                    m_d.fmt.phase_inv = wr_data[4];
                    m_d.fmt.clkout    = wr_data[5];
                    m_d.fmt.rate      = wr_data[7:6];
                    m_d.fmt.zero_det  = wr_data[8];
                end
                ADR_OUT: begin
                    m_d.outm.diff        = wr_data[5:4];
                    m_d.outm.clkloss_off = wr_data[6];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign mode = m_q;

    // R10
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr > ADR_OUT) |=> $stable(m_q));

    // R8
    fmt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_FMT) |=> (m_q.fmt.shared == $past(wr_data[2])));
endmodule

// File: rtl/chan_route.sv
module chan_route
    import atten_regs_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CODE_W-1:0]             act_l,
    input  logic [CODE_W-1:0]             act_r,
    input  logic                          shared,
    output logic [NCHAN-1:0][CODE_W-1:0]  code,
    output logic [NCHAN-1:0]              mute,
    output logic [NCHAN-1:0][CODE_W-1:0]  depth
);
    logic [NCHAN-1:0][CODE_W-1:0] src;

    always_comb begin
        src[0] = act_l;
        src[1] = shared ? act_l : act_r;
    end

    for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
        always_comb begin
            code[ch]  = src[ch];
            mute[ch]  = (src[ch] == '0);
            depth[ch] = CODE_UNITY - src[ch];
        end

        // R4
        mute_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mute[ch] |-> (depth[ch] == CODE_UNITY));
    end

    // R6
    shared_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shared |-> (code[1] == code[0] && mute[1] == mute[0]));
endmodule

// File: rtl/stereo_atten_regs.sv
module stereo_atten_regs
    import atten_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CODE_W-1:0] left_code,
    output logic [CODE_W-1:0] right_code,
    output logic              left_mute,
    output logic              right_mute,
    output logic [CODE_W-1:0] left_depth,
    output logic [CODE_W-1:0] right_depth,
    output logic              soft_mute,
    output logic              deemph_en,
    output logic              dac_run,
    output logic [1:0]        word_len,
    output logic              fmt_i2s,
    output logic              lr_polarity,
    output logic              shared_level,
    output logic              slow_rolloff,
    output logic              phase_invert,
    output logic              clkout_sel,
    output logic [1:0]        rate_sel,
    output logic              zero_detect_en,
    output logic [1:0]        diff_mode,
    output logic              clkloss_off
);
    logic [CODE_W-1:0]            act_l, act_r;
    mode_state_t                  mode;
    logic [NCHAN-1:0][CODE_W-1:0] code, depth;
    logic [NCHAN-1:0]             mute;

    atten_stage u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .act_l(act_l), .act_r(act_r)
    );

    mode_bank u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode)
    );

    chan_route u_route (
        .clk(clk), .rst_n(rst_n), .act_l(act_l), .act_r(act_r),
        .shared(mode.fmt.shared), .code(code), .mute(mute), .depth(depth)
    );

    assign left_code      = code[0];
    assign right_code     = code[1];
    assign left_mute      = mute[0];
    assign right_mute     = mute[1];
    assign left_depth     = depth[0];
    assign right_depth    = depth[1];
    assign soft_mute      = mode.ctl.soft_mute;
    assign deemph_en      = mode.ctl.deemph;
    assign dac_run        = mode.ctl.dac_run;
    assign word_len       = mode.ctl.word_len;
    assign fmt_i2s        = mode.fmt.fmt;
    assign lr_polarity    = mode.fmt.lr_pol;
    assign shared_level   = mode.fmt.shared;
    assign slow_rolloff   = mode.fmt.slow_ro;
    assign phase_invert   = mode.fmt.phase_inv;
    assign clkout_sel     = mode.fmt.clkout;
    assign rate_sel       = mode.fmt.rate;
    assign zero_detect_en = mode.fmt.zero_det;
    assign diff_mode      = mode.outm.diff;
    assign clkloss_off    = mode.outm.clkloss_off;
endmodule

// File: tb/sim_stereo_atten_regs.sv
`timescale 1ns/1ps
module sim_stereo_atten_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic [7:0] left_code, right_code, left_depth, right_depth;
    logic       left_mute, right_mute;
    logic       soft_mute, deemph_en, dac_run, fmt_i2s, lr_polarity, shared_level;
    logic       slow_rolloff, phase_invert, clkout_sel, zero_detect_en, clkloss_off;
    logic [1:0] word_len, rate_sel, diff_mode;

    always #4 clk = ~clk;

    stereo_atten_regs u0 (.*);

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_stg_l, m_stg_r, m_act_l, m_act_r;
    logic [4:0] m_ctl;
    logic [8:0] m_fmt;
    logic [2:0] m_out;

    function automatic logic [7:0] exp_depth(input logic [7:0] x);
        return 8'(9'd255 - {1'b0, x});
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0] er;
        er = m_fmt[2] ? m_act_l : m_act_r;
        chk({tag, " left code"}, {8'h0, left_code}, {8'h0, m_act_l});
        chk({tag, " right code R6"}, {8'h0, right_code}, {8'h0, er});
        chk("R5 mute", {14'h0, left_mute, right_mute}, {14'h0, m_act_l == 8'h0, er == 8'h0});
        chk("R4 depth", {left_depth, right_depth}, {exp_depth(m_act_l), exp_depth(er)});
        chk("R7 ctl fields", {11'h0, word_len, dac_run, deemph_en, soft_mute}, {11'h0, m_ctl});
        chk("R8 fmt fields",
            {7'h0, zero_detect_en, rate_sel, clkout_sel, phase_invert, slow_rolloff,
             shared_level, lr_polarity, fmt_i2s}, {7'h0, m_fmt});
        chk("R9 out fields", {13'h0, clkloss_off, diff_mode}, {13'h0, m_out});
    endtask

    task automatic model_write(input logic [2:0] a, input logic [8:0] d);
        case (a)
            3'd0: begin m_stg_l = d[7:0]; if (d[8]) begin m_act_l = m_stg_l; m_act_r = m_stg_r; end end
            3'd1: begin m_stg_r = d[7:0]; if (d[8]) begin m_act_l = m_stg_l; m_act_r = m_stg_r; end end
            3'd2: m_ctl = d[4:0];
            3'd3: m_fmt = d;
            3'd4: m_out = d[6:4];
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [2:0] a, input logic [8:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        check_all(tag);
    endtask

    function automatic logic [7:0] pick_code();
        case ($urandom_range(0, 5))
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'hFE;
            3: return 8'hFF;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_stg_l = 8'hFF; m_stg_r = 8'hFF; m_act_l = 8'hFF; m_act_r = 8'hFF;
        m_ctl = '0; m_fmt = '0; m_out = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2: staging only
        do_write(3'd0, 9'h012, "R2 stage left");
        do_write(3'd1, 9'h034, "R2 stage right");
        // R3: load via right write includes new right value and staged left
        do_write(3'd1, 9'h156, "R3 load right");
        // R3: load via left with mute and unity edges
        do_write(3'd1, 9'h000, "R2 stage mute");
        do_write(3'd0, 9'h101, "R3 load left");
        do_write(3'd0, 9'h1FE, "R3 reload");
        // R6: shared mode on then off
        do_write(3'd3, 9'h004, "R6 shared on");
        do_write(3'd0, 9'h100, "R6 shared mute");
        do_write(3'd3, 9'h000, "R6 shared off");
        // R10: ignored addresses and idle strobe
        do_write(3'd5, 9'h1FF, "R10 addr5");
        do_write(3'd7, 9'h1AA, "R10 addr7");
        @(negedge clk);
        wr_addr = 3'd0; wr_data = 9'h155; wr_en = 1'b0;
        @(negedge clk);
        check_all("R10 wr_en low");
        do_write(3'd2, 9'h1FF, "R7 ctl");
        do_write(3'd4, 9'h1FF, "R9 out");
        do_write(3'd3, 9'h1FB, "R8 fmt");

        for (int i = 0; i < 400; i++) begin
            logic [2:0] a;
            logic [8:0] d;
            a = 3'($urandom_range(0, 7));
            d = 9'($urandom);
            if (a <= 3'd1) d[7:0] = pick_code();
            do_write(a, d, "R3 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule